// File: doc/BRIEF.md
# Runnable Frame Dispatcher

This block schedules activation frames on one processing node. A frame that is not running collects thread addresses posted to it in a small per-frame pending buffer. The first such post also places the frame at the tail of a first-in first-out queue of runnable frames. Later posts only add threads to the buffer.

When the running frame runs out of local work, the local scheduler raises a swap request. The block then emits the outgoing frame's leave-thread address and takes the oldest runnable frame from the queue. It pushes that frame's pending threads onto the local thread stack one per cycle and emits the frame's enter-thread address. If the queue is empty, the block reports idle. The next post to any frame restarts dispatch.

Enter and leave addresses are written per frame through a small configuration port. Frame allocation and release are handled elsewhere.

Top module: `frame_sched`

## Requirements
- R1: After reset, `run_valid`, `lcv_push_valid`, `cur_valid` and every bit of `ovf_err` are 0, and `idle` is 1.
- R2: A post to a frame that is not running stores the thread address in that frame's pending buffer. When the frame is dispatched, its stored addresses appear on `lcv_push_pc` one per cycle, oldest first, and the buffer is then emptied.
- R3: Only the first post to a frame that is neither running nor queued enqueues it. A frame is dispatched once per enqueue, however many posts it received. A frame that received no post is never dispatched.
- R4: Queued frames are dispatched in the order in which each received its enqueuing post.
- R5: `swap_req` sampled high while a frame runs gives `run_valid`=1 with that frame's leave address on the next cycle, and `cur_valid` drops in that same cycle.
- R6: After the last pending push of a dispatched frame, `run_valid` pulses with the frame's enter address. From the dequeue onward, `cur_valid`=1 and `cur_frame` names that frame. `run_valid` and `lcv_push_valid` are never high together.
- R7: If a swap leaves the runnable queue empty, `idle` is 1 and `cur_valid` is 0. The next accepted post dispatches its frame with no further swap.
- R8: Each pending buffer holds DEPTH entries. A post to a full buffer is dropped and sets that frame's `ovf_err` bit, which stays set until reset.
- R9: A post addressed to the running frame (including a frame being dequeued in that cycle) is ignored. It is neither stored nor used to enqueue the frame.
- R10: A `cfg_we` write sets the enter and leave addresses of `cfg_frame`. Later swaps and dispatches use the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write enter/leave addresses of `cfg_frame` |
| cfg_frame | input | FID_W | Frame being configured |
| cfg_enter_pc | input | PC_W | Enter-thread address |
| cfg_leave_pc | input | PC_W | Leave-thread address |
| post_valid | input | 1 | Thread post strobe |
| post_frame | input | FID_W | Target frame of the post |
| post_pc | input | PC_W | Posted thread address |
| swap_req | input | 1 | Running frame has no local work left |
| run_valid | output | 1 | Leave or enter thread to branch to |
| run_pc | output | PC_W | Address of that thread |
| lcv_push_valid | output | 1 | Push onto local thread stack |
| lcv_push_pc | output | PC_W | Address pushed |
| cur_valid | output | 1 | A frame is running or being dispatched |
| cur_frame | output | FID_W | That frame |
| idle | output | 1 | No running frame and queue empty |
| ovf_err | output | NFRAMES | Sticky per-frame pending-buffer overflow |

## Verification
The assertions check the following on every cycle:
- the runnable queue is never pushed when full or popped when empty, which shows the queued flags prevent double enqueue;
- a swap yields the leave pulse on the next cycle;
- the two output strobes never overlap;
- idle never coexists with a running frame;
- pending counts stay within DEPTH;
- overflow flags never clear.

Only the bench scenarios can show the rest:
- the dispatch order across frames;
- the oldest-first order of transferred threads;
- that ignored and overflowing posts leave no trace in later pushes;
- that a frame with no posts is never dispatched.

// File: rtl/fsched_pkg.sv
package fsched_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_XFER = 2'd1,
    S_RUN  = 2'd2
  } sched_state_t;
endpackage

// File: rtl/fsched_fifo.sv
module fsched_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     ram [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic [CNT_W-1:0] cnt;

  assign head  = ram[rp];
  assign empty = (cnt == '0);
  assign full  = (cnt == CNT_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (push) ram[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == PTR_W'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CNT_W'(push) - CNT_W'(pop);
    end
  end

  // queued flags must keep the frame queue from ever overfilling
  p_no_push_full_r3: assert property (@(posedge clk) disable iff (rst) push |-> !full);
  p_no_pop_empty_r4: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);
endmodule

// File: rtl/fsched_rcv.sv
module fsched_rcv #(
  parameter int NF    = 4,
  parameter int DEP   = 3,
  parameter int PC_W  = 8,
  parameter int FID_W = $clog2(NF),
  parameter int CNT_W = $clog2(DEP + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [FID_W-1:0] wr_frame,
  input  logic [PC_W-1:0]  wr_pc,
  input  logic [FID_W-1:0] rd_frame,
  input  logic [CNT_W-1:0] rd_idx,
  output logic [PC_W-1:0]  rd_pc,
  output logic [CNT_W-1:0] rd_cnt,
  input  logic             clr,
  output logic [NF-1:0]    err
);
  localparam int AW = $clog2(NF * DEP);

  logic [PC_W-1:0]  mem [NF * DEP];
  logic [CNT_W-1:0] cnt_q [NF];
  logic [AW-1:0]    waddr, raddr;
  logic             wfull;

  assign wfull = (cnt_q[wr_frame] == CNT_W'(DEP));
  assign waddr = AW'(wr_frame) * AW'(DEP) + AW'(cnt_q[wr_frame]);
  assign raddr = AW'(rd_frame) * AW'(DEP) + AW'(rd_idx);
  assign rd_pc  = mem[raddr];
  assign rd_cnt = cnt_q[rd_frame];

  always_ff @(posedge clk) begin
    if (wr_en && !wfull) mem[waddr] <= wr_pc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NF; i++) cnt_q[i] <= '0;
      err <= '0;
    end else begin
      if (wr_en) begin
        if (wfull) err[wr_frame] <= 1'b1;
        else       cnt_q[wr_frame] <= cnt_q[wr_frame] + 1'b1;
      end
      if (clr) cnt_q[rd_frame] <= '0;
    end
  end

  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (rst) rd_cnt <= CNT_W'(DEP));
endmodule

// File: rtl/frame_sched.sv
module frame_sched #(
  parameter int NFRAMES = 4,
  parameter int DEPTH   = 3,
  parameter int PC_W    = 8,
  localparam int FID_W  = $clog2(NFRAMES),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [FID_W-1:0]   cfg_frame,
  input  logic [PC_W-1:0]    cfg_enter_pc,
  input  logic [PC_W-1:0]    cfg_leave_pc,
  input  logic               post_valid,
  input  logic [FID_W-1:0]   post_frame,
  input  logic [PC_W-1:0]    post_pc,
  input  logic               swap_req,
  output logic               run_valid,
  output logic [PC_W-1:0]    run_pc,
  output logic               lcv_push_valid,
  output logic [PC_W-1:0]    lcv_push_pc,
  output logic               cur_valid,
  output logic [FID_W-1:0]   cur_frame,
  output logic               idle,
  output logic [NFRAMES-1:0] ovf_err
);
  import fsched_pkg::*;

  sched_state_t     st;
  logic [PC_W-1:0]  enter_tab [NFRAMES];
  logic [PC_W-1:0]  leave_tab [NFRAMES];
  logic [NFRAMES-1:0] queued;
  logic [CNT_W-1:0] xidx;

  logic             q_empty, q_full, pop, enq, post_ok, to_running;
  logic [FID_W-1:0] q_head;
  logic [PC_W-1:0]  rd_pc;
  logic [CNT_W-1:0] rd_cnt;
  logic             xfer_done;

  assign pop        = (st == S_IDLE) && !q_empty;
  assign to_running = (cur_valid && post_frame == cur_frame) || (pop && post_frame == q_head);
  assign post_ok    = post_valid && !to_running;
  assign enq        = post_ok && !queued[post_frame];
  assign xfer_done  = (st == S_XFER) && (xidx == rd_cnt);
  assign idle       = (st == S_IDLE) && q_empty;

  fsched_fifo #(.DEPTH(NFRAMES), .W(FID_W)) u_runq (
    .clk(clk), .rst(rst), .push(enq), .push_data(post_frame),
    .pop(pop), .head(q_head), .empty(q_empty), .full(q_full)
  );

  fsched_rcv #(.NF(NFRAMES), .DEP(DEPTH), .PC_W(PC_W)) u_rcv (
    .clk(clk), .rst(rst), .wr_en(post_ok), .wr_frame(post_frame), .wr_pc(post_pc),
    .rd_frame(cur_frame), .rd_idx(xidx), .rd_pc(rd_pc), .rd_cnt(rd_cnt),
    .clr(xfer_done), .err(ovf_err)
  );

  always_ff @(posedge clk) begin
    if (cfg_we) begin
      enter_tab[cfg_frame] <= cfg_enter_pc;
      leave_tab[cfg_frame] <= cfg_leave_pc;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) queued <= '0;
    else begin
      if (enq) queued[post_frame] <= 1'b1;
      if (pop) queued[q_head]     <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st             <= S_IDLE;
      run_valid      <= 1'b0;
      run_pc         <= '0;
      lcv_push_valid <= 1'b0;
      lcv_push_pc    <= '0;
      cur_valid      <= 1'b0;
      cur_frame      <= '0;
      xidx           <= '0;
    end else begin
      run_valid      <= 1'b0;
      lcv_push_valid <= 1'b0;
      case (st)
        S_IDLE: if (pop) begin
          cur_frame <= q_head;
          cur_valid <= 1'b1;
          xidx      <= '0;
          st        <= S_XFER;
        end
        S_XFER: if (xfer_done) begin
          run_valid <= 1'b1;
          run_pc    <= enter_tab[cur_frame];
          st        <= S_RUN;
        end else begin
          lcv_push_valid <= 1'b1;
          lcv_push_pc    <= rd_pc;
          xidx           <= xidx + 1'b1;
        end
        S_RUN: if (swap_req) begin
          run_valid <= 1'b1;
          run_pc    <= leave_tab[cur_frame];
          cur_valid <= 1'b0;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_swap_leaves_r5: assert property (@(posedge clk) disable iff (rst)
    (st == S_RUN && swap_req) |=> (run_valid && !cur_valid));
  p_one_stream_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({run_valid, lcv_push_valid}));
  p_idle_no_frame_r7: assert property (@(posedge clk) disable iff (rst)
    idle |-> !cur_valid);
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (ovf_err & $past(ovf_err)) == $past(ovf_err));
endmodule

// File: tb/frame_sched_bench.sv
`timescale 1ns/1ps
module frame_sched_bench;
  localparam int NF = 4, DEP = 3, PCW = 8, FW = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 0, post_valid = 0, swap_req = 0;
  logic [FW-1:0] cfg_frame = 0, post_frame = 0;
  logic [PCW-1:0] cfg_enter_pc = 0, cfg_leave_pc = 0, post_pc = 0;
  logic run_valid, lcv_push_valid, cur_valid, idle;
  logic [PCW-1:0] run_pc, lcv_push_pc;
  logic [FW-1:0] cur_frame;
  logic [NF-1:0] ovf_err;

  always #2.5 clk = ~clk;

  frame_sched #(.NFRAMES(NF), .DEPTH(DEP), .PC_W(PCW)) u_frame_sched (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_frame(cfg_frame),
    .cfg_enter_pc(cfg_enter_pc), .cfg_leave_pc(cfg_leave_pc),
    .post_valid(post_valid), .post_frame(post_frame), .post_pc(post_pc),
    .swap_req(swap_req), .run_valid(run_valid), .run_pc(run_pc),
    .lcv_push_valid(lcv_push_valid), .lcv_push_pc(lcv_push_pc),
    .cur_valid(cur_valid), .cur_frame(cur_frame), .idle(idle), .ovf_err(ovf_err)
  );

  int checks = 0, fails = 0;
  int lk [512]; int lp [512]; int ln = 0;
  int ek [512]; int ep [512]; int en = 0;
  int cmp_from = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // log of output events: kind 0 = run thread, 1 = local stack push
  always @(negedge clk) begin
    if (!rst && ln < 510) begin
      if (run_valid)      begin lk[ln] = 0; lp[ln] = run_pc;      ln++; end
      if (lcv_push_valid) begin lk[ln] = 1; lp[ln] = lcv_push_pc; ln++; end
    end
  end

  task automatic exp_ev(input int k, input int pc);
    ek[en] = k; ep[en] = pc; en++;
  endtask

  task automatic compare(input string req);
    chk(ln == en, {req, " event count"}, ln, en);
    for (int i = cmp_from; i < en && i < ln; i++)
      chk(lk[i] == ek[i] && lp[i] == ep[i], req, lk[i] * 256 + lp[i], ek[i] * 256 + ep[i]);
    cmp_from = en;
  endtask

  task automatic post(input int f, input int pc);
    post_valid = 1; post_frame = FW'(f); post_pc = PCW'(pc);
    @(negedge clk);
    post_valid = 0;
  endtask

  task automatic swap(input int leave);
    swap_req = 1;
    @(negedge clk);
    swap_req = 0;
    chk(run_valid && run_pc == PCW'(leave) && !cur_valid, "R5 leave next cycle",
        {run_valid, cur_valid, run_pc}, {2'b10, PCW'(leave)});
    exp_ev(0, leave);
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!run_valid && !lcv_push_valid && !cur_valid && idle && ovf_err == 0, "R1 reset state",
        {run_valid, lcv_push_valid, cur_valid, idle, ovf_err}, 8'b0001_0000);

    // R10: configure enter 0x10+f, leave 0x20+f
    for (int f = 0; f < NF; f++) begin
      cfg_we = 1; cfg_frame = FW'(f); cfg_enter_pc = PCW'(16 + f); cfg_leave_pc = PCW'(32 + f);
      @(negedge clk);
    end
    cfg_we = 0;

    // R7 restart from idle, R2 transfer, R6 enter
    post(0, 'h40);
    exp_ev(1, 'h40); exp_ev(0, 'h10);
    settle();
    compare("R2 R6 first dispatch");
    chk(cur_valid && cur_frame == 0 && !idle, "R6 current frame", cur_frame, 0);

    // build queue while frame 0 runs
    post(2, 'h50); post(2, 'h51); post(1, 'h48);
    for (int k = 0; k < 4; k++) post(3, 'h58 + k);  // R8 overflow on the fourth
    post(0, 'h41);                                  // R9 ignored
    post(2, 'h52);
    cfg_we = 1; cfg_frame = 0; cfg_enter_pc = 'h10; cfg_leave_pc = 'h30;  // R10
    @(negedge clk);
    cfg_we = 0;
    chk(ovf_err == 4'b1000, "R8 overflow flag", ovf_err, 4'b1000);

    swap('h30);  // R10 new leave address
    exp_ev(1, 'h50); exp_ev(1, 'h51); exp_ev(1, 'h52); exp_ev(0, 'h12);
    settle();
    compare("R4 R2 frame 2 first in order");
    chk(cur_frame == 2, "R4 dispatch order", cur_frame, 2);

    swap('h22);
    exp_ev(1, 'h48); exp_ev(0, 'h11);
    settle();
    compare("R4 frame 1 second");

    swap('h21);
    exp_ev(1, 'h58); exp_ev(1, 'h59); exp_ev(1, 'h5A); exp_ev(0, 'h13);
    settle();
    compare("R8 overflow entry dropped");
    chk(ovf_err == 4'b1000, "R8 sticky flag", ovf_err, 4'b1000);

    swap('h23);
    settle();
    chk(idle && !cur_valid, "R7 idle on empty queue", {idle, cur_valid}, 2'b10);
    compare("R7 nothing dispatched");

    post(0, 'h42);
    exp_ev(1, 'h42); exp_ev(0, 'h10);
    settle();
    compare("R9 ignored post absent, R7 restart");

    // sweep of post counts to frame 1
    for (int n = 0; n <= DEP + 1; n++) begin
      for (int k = 0; k < n; k++) post(1, 'h70 + k);
      swap('h30);
      if (n == 0) begin
        settle();
        chk(idle && !cur_valid, "R3 no post no dispatch", {idle, cur_valid}, 2'b10);
      end else begin
        for (int k = 0; k < n && k < DEP; k++) exp_ev(1, 'h70 + k);
        exp_ev(0, 'h11);
        settle();
        chk(cur_frame == 1 && cur_valid, "R3 frame dispatched", cur_frame, 1);
        swap('h21);
        settle();
        chk(idle, "R3 dispatched once", idle, 1);
      end
      chk(ovf_err[1] == (n > DEP), "R8 overflow per frame", ovf_err[1], (n > DEP));
      compare("R3 R2 sweep");
      post(0, 'h60 + n);
      exp_ev(1, 'h60 + n); exp_ev(0, 'h10);
      settle();
      compare("R2 restart frame 0");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule